// File: doc/BRIEF.md
# BCD Watchdog Countdown Timer

This block is a decimal watchdog. Software programs an interval between 00.01 and 99.99 seconds as four BCD digits, split over two byte registers: one for hundredths of a second and one for whole seconds. A 100 Hz tick input steps a hidden countdown down by one hundredth per tick. When the countdown runs out, the watchdog flag rises and the active-low interrupt is driven. The countdown then reloads itself and keeps running.

Any access to either interval register restarts the countdown from the programmed interval and clears the flag and the interrupt. This holds for reads as well as writes. A program that touches the registers often enough therefore never sees the alarm. Reads always return the programmed interval and never the live count. An interval of zero switches the watchdog off.

Top module: `bcd_watchdog`

## Requirements
- R1: The hundredths register sits at address 4'hC and the seconds register at 4'hD. Each holds two BCD digits, with the tens digit in bits [7:4] and the units digit in bits [3:0]. Each register is written on its own, in either order. The interval in ticks is 100 × seconds + hundredths.
- R2: An access is a cycle with `bus_sel` high and `bus_addr` equal to 4'hC or 4'hD, either a read (`bus_wr` low) or a write. At that clock edge the countdown reloads from the programmed value, including any byte written in the same cycle. The flag and the interrupt clear at the same edge.
- R3: With a nonzero interval of N ticks, `wd_flag` goes high and `wd_irq_n` goes low at the clock edge that takes the Nth tick after the last access, and not before.
- R4: On running out, the countdown reloads and starts again. The flag and the interrupt stay asserted through later countdowns until the next access.
- R5: `bus_rdata` shows the programmed byte whenever `bus_addr` is 4'hC or 4'hD, in the same cycle and without a clock edge. It shows 8'h00 at any other address. The live countdown is never visible.
- R6: While both registers hold zero, the watchdog is disabled and no number of ticks raises the flag.
- R7: The countdown steps in BCD with a borrow across all four digits. An interval of 01.00 takes exactly 100 ticks and 99.99 takes exactly 9999 ticks.
- R8: After reset both registers read zero, `wd_flag` is low and `wd_irq_n` is high, so the watchdog starts out disabled.
- R9: Bus cycles to any other address neither restart the countdown nor clear the flag.
- R10: A tick that arrives in the same cycle as an access is not counted. The full interval is still needed after that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_100hz | input | 1 | One-cycle pulse per hundredth of a second |
| bus_sel | input | 1 | Bus cycle strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational on address) |
| wd_flag | output | 1 | Watchdog expired flag, active high |
| wd_irq_n | output | 1 | Watchdog interrupt, active low |

## Verification
Read data is combinational, so it is due in the cycle the address is presented. The bench samples it a moment after driving the address on the falling edge, before the register edge. The flag and interrupt change on the rising edge that takes the Nth tick, or the access, so the bench checks them on the next falling edge. Checking one tick early (flag still low) and then at the exact tick pins each interval, including 9999, to the cycle. Reset passes through a two-stage synchronizer, so the bench allows three edges after release before its first check.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  localparam int unsigned BCD_W = 4;

  typedef logic [BCD_W-1:0] bcd_digit_t;

  // Decrement one BCD digit with borrow in; returns {borrow_out, digit}.
  function automatic logic [BCD_W:0] bcd_digit_dec(input bcd_digit_t d, input logic bin);
    logic [BCD_W:0] r;
    if (!bin) begin
      r = {1'b0, d};
    end else if (d == '0) begin
      r = {1'b1, 4'd9};
    end else begin
      r = {1'b0, d - 4'd1};
    end
    return r;
  endfunction
endpackage

// File: rtl/bwd_regs.sv
module bwd_regs #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NREG = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 4'hC,
  localparam int unsigned PW = NREG * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              access,
  output logic [PW-1:0]     prog,
  output logic [PW-1:0]     prog_nxt,
  output logic [DATA_W-1:0] rdata
);
  logic [NREG-1:0] hit;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DATA_W-1:0] byte_q;
    logic              byte_en;

    assign hit[g]   = (addr == BASE_ADDR + ADDR_W'(g));
    assign byte_en  = sel & wr & hit[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
      end else if (byte_en) begin
        byte_q <= wdata;
      end
    end

    assign prog[g*DATA_W +: DATA_W]     = byte_q;
    assign prog_nxt[g*DATA_W +: DATA_W] = byte_en ? wdata : byte_q;
  end

  assign access = sel & (|hit);

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit[i]) rdata = prog[i*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/bwd_bcd_down.sv
module bwd_bcd_down
  import bwd_pkg::*;
#(
  parameter int unsigned DIGITS = 4,
  localparam int unsigned W = DIGITS * BCD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         at_one
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic [W-1:0] dec_val;
  logic         cnt_en;

  always_comb begin
    logic           bw;
    logic [BCD_W:0] step;
    bw = 1'b1;
    dec_val = '0;
    for (int d = 0; d < DIGITS; d++) begin
      step = bcd_digit_dec(cnt_q[d*BCD_W +: BCD_W], bw);
      dec_val[d*BCD_W +: BCD_W] = step[BCD_W-1:0];
      bw = step[BCD_W];
    end
  end

  assign cnt_en = load | dec;

  always_comb begin
    cnt_d = load ? load_val : dec_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt    = cnt_q;
  assign at_one = (cnt_q == ONE);
endmodule

// File: rtl/bwd_ctrl.sv
module bwd_ctrl #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         access,
  input  logic         tick,
  input  logic [W-1:0] prog,
  input  logic         at_one,
  output logic         load,
  output logic         dec,
  output logic         flag
);
  logic enabled;
  logic counting;
  logic expire;
  logic flag_q;
  logic flag_d;
  logic flag_en;

  assign enabled  = (prog != '0);
  assign counting = ~access & tick & enabled;
  assign expire   = counting & at_one;

  always_comb begin
    load = access | expire;
    dec  = counting & ~at_one;
  end

  assign flag_en = access | expire;

  always_comb begin
    flag_d = access ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/bcd_watchdog.sv
module bcd_watchdog #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NREG = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 4'hC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_100hz,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wd_flag,
  output logic              wd_irq_n
);
  localparam int unsigned PW     = NREG * DATA_W;
  localparam int unsigned DIGITS = PW / bwd_pkg::BCD_W;

  logic [1:0]    rst_sync_q;
  logic          rst_ni;
  logic          access;
  logic [PW-1:0] prog;
  logic [PW-1:0] prog_nxt;
  logic [PW-1:0] cnt;
  logic          at_one;
  logic          load;
  logic          dec;
  logic          flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_ni = rst_sync_q[1];

  bwd_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(NREG), .BASE_ADDR(BASE_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_ni), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .access(access), .prog(prog), .prog_nxt(prog_nxt),
    .rdata(bus_rdata)
  );

  bwd_ctrl #(.W(PW)) u_ctrl (
    .clk(clk), .rst_n(rst_ni), .access(access), .tick(tick_100hz),
    .prog(prog), .at_one(at_one), .load(load), .dec(dec), .flag(flag)
  );

  bwd_bcd_down #(.DIGITS(DIGITS)) u_cnt (
    .clk(clk), .rst_n(rst_ni), .load(load), .load_val(prog_nxt), .dec(dec),
    .cnt(cnt), .at_one(at_one)
  );

  assign wd_flag  = flag;
  assign wd_irq_n = ~flag;
endmodule

// File: rtl/bwd_chk.sv
module bwd_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_ni,
  input logic         access,
  input logic         tick,
  input logic         flag,
  input logic [W-1:0] prog,
  input logic [W-1:0] prog_nxt,
  input logic [W-1:0] cnt
);
  // R2
  access_clear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    access |=> !flag);

  // R3
  flag_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!flag && !tick) |=> !flag);

  // R6
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (prog == '0 && !flag) |=> !flag);

  // R4
  reload_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (prog != '0 && !access) |=> (cnt != '0));

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (flag && !access) |=> flag);

  // R10
  access_reload_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    access |=> (cnt == $past(prog_nxt)));
endmodule

bind bcd_watchdog bwd_chk #(.W(PW)) u_chk (
  .clk(clk), .rst_ni(rst_ni), .access(access), .tick(tick_100hz),
  .flag(flag), .prog(prog), .prog_nxt(prog_nxt), .cnt(cnt)
);

// File: tb/bcd_watchdog_tb.sv
module bcd_watchdog_tb;
  localparam time CLK_T = 20ns;
  localparam int NV = 21;
  // {op[1:0] (0 none,1 write,2 read), addr[3:0], data[7:0], ticks[15:0], exp_flag, chk_rd, exp_rd[7:0]}
  localparam logic [39:0] VEC [NV] = '{
    {2'd1, 4'hC, 8'h05, 16'd4,   1'b0, 1'b0, 8'h00}, // R1 5 ticks, one short
    {2'd0, 4'h0, 8'h00, 16'd1,   1'b1, 1'b0, 8'h00}, // R3 exactly 5th tick
    {2'd0, 4'h0, 8'h00, 16'd12,  1'b1, 1'b0, 8'h00}, // R4 repeats, stays set
    {2'd2, 4'hC, 8'h00, 16'd0,   1'b0, 1'b1, 8'h05}, // R2 R5 read clears
    {2'd0, 4'h0, 8'h00, 16'd4,   1'b0, 1'b0, 8'h00}, // R2 read restarted
    {2'd0, 4'h0, 8'h00, 16'd1,   1'b1, 1'b0, 8'h00}, // R3
    {2'd1, 4'hD, 8'h01, 16'd104, 1'b0, 1'b0, 8'h00}, // R1 R7 01.05
    {2'd0, 4'h0, 8'h00, 16'd1,   1'b1, 1'b0, 8'h00}, // R7
    {2'd1, 4'hC, 8'h00, 16'd99,  1'b0, 1'b0, 8'h00}, // R7 01.00
    {2'd0, 4'h0, 8'h00, 16'd1,   1'b1, 1'b0, 8'h00}, // R7
    {2'd1, 4'hD, 8'h00, 16'd250, 1'b0, 1'b0, 8'h00}, // R6 zero disables
    {2'd2, 4'hD, 8'h00, 16'd0,   1'b0, 1'b1, 8'h00}, // R5
    {2'd2, 4'h3, 8'h00, 16'd0,   1'b0, 1'b1, 8'h00}, // R5 other address
    {2'd1, 4'hC, 8'h10, 16'd9,   1'b0, 1'b0, 8'h00}, // R1 order C after D
    {2'd0, 4'h0, 8'h00, 16'd1,   1'b1, 1'b0, 8'h00}, // R1
    {2'd1, 4'h3, 8'h55, 16'd0,   1'b1, 1'b0, 8'h00}, // R9 no clear
    {2'd2, 4'hC, 8'h00, 16'd5,   1'b0, 1'b1, 8'h10}, // R5 R2
    {2'd1, 4'h7, 8'hAA, 16'd4,   1'b0, 1'b0, 8'h00}, // R9 no restart
    {2'd0, 4'h0, 8'h00, 16'd1,   1'b1, 1'b0, 8'h00}, // R9 10 ticks total
    {2'd2, 4'h7, 8'h00, 16'd0,   1'b1, 1'b1, 8'h00}, // R9 R5 read elsewhere
    {2'd1, 4'hD, 8'h00, 16'd3,   1'b0, 1'b0, 8'h00}  // R2 write clears
  };

  logic       clk;
  logic       rst_n;
  logic       tick_100hz;
  logic       bus_sel;
  logic       bus_wr;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       wd_flag;
  logic       wd_irq_n;

  int n_checks = 0;
  int n_errors = 0;

  bcd_watchdog u_dut (
    .clk(clk), .rst_n(rst_n), .tick_100hz(tick_100hz), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wd_flag(wd_flag), .wd_irq_n(wd_irq_n)
  );

  initial clk = 1'b0;
  always #(CLK_T / 2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_flag(input string req, input logic exp);
    check({req, " flag"}, int'(wd_flag), int'(exp));
    check({req, " irq_n"}, int'(wd_irq_n), int'(!exp));
  endtask

  // one bus cycle; rdata sampled before the edge, optional tick in same cycle
  task automatic bus(input logic wr, input logic [3:0] a, input logic [7:0] d,
                     input logic with_tick, input logic chk_rd, input logic [7:0] exp_rd,
                     input string req);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d; tick_100hz = with_tick;
    #1;
    if (chk_rd) check(req, int'(bus_rdata), int'(exp_rd));
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; tick_100hz = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_100hz = 1'b1;
    end
    if (n > 0) begin
      @(negedge clk);
      tick_100hz = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_T * 150000);
    n_errors++;
    $display("FAIL watchdog: run hung");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick_100hz = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = 4'h0; bus_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8 reset state, read data needs no access
    check_flag("R8", 1'b0);
    bus_addr = 4'hC; #1; check("R8 hund", int'(bus_rdata), 0);
    bus_addr = 4'hD; #1; check("R8 secs", int'(bus_rdata), 0);
    ticks(50);
    check_flag("R8 disabled after reset", 1'b0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      logic [1:0]  op;
      logic [3:0]  a;
      logic [7:0]  d;
      logic [15:0] nt;
      logic        ef, cr;
      logic [7:0]  er;
      {op, a, d, nt, ef, cr, er} = VEC[v];
      if (op == 2'd1) bus(1'b1, a, d, 1'b0, 1'b0, 8'h00, "R1");
      else if (op == 2'd2) bus(1'b0, a, 8'h00, 1'b0, cr, er, $sformatf("R5 vec %0d", v));
      ticks(int'(nt));
      check_flag($sformatf("R3 vec %0d", v), ef);
    end

    // R10 tick in the access cycle is ignored
    bus(1'b1, 4'hC, 8'h03, 1'b1, 1'b0, 8'h00, "R10");
    ticks(2);
    check_flag("R10 one short", 1'b0);
    ticks(1);
    check_flag("R10 full interval", 1'b1);

    // R7 largest interval 99.99
    bus(1'b1, 4'hD, 8'h99, 1'b0, 1'b0, 8'h00, "R7");
    bus(1'b1, 4'hC, 8'h99, 1'b0, 1'b1, 8'h03, "R7 old hund");
    ticks(9998);
    check_flag("R7 9998", 1'b0);
    ticks(1);
    check_flag("R7 9999", 1'b1);

    // R4 after many repeats flag still set, then access clears
    ticks(300);
    check_flag("R4 sticky", 1'b1);
    bus(1'b0, 4'hD, 8'h00, 1'b0, 1'b1, 8'h99, "R5 secs");
    check_flag("R2 read clears", 1'b0);

    // R8 reset mid-run
    do_reset();
    check_flag("R8 reset clears", 1'b0);
    bus_addr = 4'hD; #1; check("R8 secs zeroed", int'(bus_rdata), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule